// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a processor's data path and a longword-organised memory or I/O port. It takes one data access (a byte address, a length of 1, 2 or 4 bytes, a read/write flag and right-aligned write data) together with the already translated address of the following longword. That second address may lie on a different page, so it is not assumed to be contiguous with the first. The block breaks the access into one or two fragments. Each fragment stays inside one aligned longword and carries exactly the bytes it needs, never a whole longword padded out.

Fragments go to a downstream port one at a time, using a valid/ready handshake. Each fragment is finished when the downstream side pulses a completion strobe, which carries right-aligned read data for reads. After the last completion the block shows the reassembled, right-aligned read result for one cycle and then accepts the next access. Accesses that need no split (aligned ones, and words at byte offsets 0, 1 and 2) pass through as a single unchanged fragment.

Top module: `unaligned_splitter`

## Requirements
- R1: During and right after reset, req_ready is 1, frag_valid is 0 and rsp_valid is 0.
- R2: A byte access, an aligned longword, or a word at byte offset 0, 1 or 2 produces exactly one fragment, at the request address, with frag_len equal to the request length (1, 2 or 4). Every fragment satisfies addr[1:0] + frag_len <= 4.
- R3: A longword at byte offset bo (1 to 3) produces two fragments. The first is 4-bo bytes at the request address. The second is bo bytes at offset 0 of the second longword address.
- R4: A word at byte offset 3 produces two 1-byte fragments. The byte from the second fragment appears in bits 15:8 of the result.
- R5: For a read, rsp_rdata equals (low data) OR (high data shifted left by 8 times the first fragment length), masked to the request length. For a write, rsp_rdata is 0.
- R6: Bits of frag_rdata above the current fragment's length have no effect on rsp_rdata.
- R7: For a write, the first fragment's data is req_wdata masked to its length. The second fragment's data is req_wdata shifted right by 8 times the first fragment's length, then masked to the second fragment's length.
- R8: The second fragment's address is the second longword address with bits 1:0 forced to 0, whatever those input bits were.
- R9: Fragments are issued strictly in order, low first, with one outstanding at a time. frag_valid stays low from a fragment's handshake until its completion strobe. rsp_valid is high for exactly one cycle, in the cycle after the last completion.
- R10: While frag_valid is high and frag_ready is low, frag_valid, frag_addr, frag_len and frag_wdata hold steady.
- R11: req_ready is high only when no access is in progress. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | AW | Byte address of the access |
| req_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-aligned write data |
| req_next_lw | input | AW | Physical address of the following longword |
| frag_valid | output | 1 | Fragment offered downstream |
| frag_ready | input | 1 | Downstream takes the fragment |
| frag_addr | output | AW | Byte address of the fragment |
| frag_len | output | 3 | Fragment length in bytes, 1 to 4 |
| frag_write | output | 1 | Fragment direction |
| frag_wdata | output | 32 | Right-aligned, masked fragment write data |
| frag_rvalid | input | 1 | Completion strobe for the outstanding fragment |
| frag_rdata | input | 32 | Right-aligned fragment read data |
| rsp_valid | output | 1 | One-cycle completion of the whole access |
| rsp_rdata | output | 32 | Right-aligned, masked read result |

## Verification
The split rule is tried with longwords at every byte offset, words at all four offsets and bytes at odd offsets. This tells the single-fragment cases (including the word at offset 1) apart from the two-fragment ones, and the longword split apart from the word split at offset 3. Reads return downstream data with random upper bits, which exposes a missing mask or a wrong reassembly shift. Writes use distinct byte values, so a wrong right shift or mask on the high fragment shows up. The second longword address is given with nonzero low bits, ready is delayed by varying amounts, and garbage requests are held on the request port while busy. These cover address forcing, holding fields under backpressure, and ignoring requests while busy.

// File: rtl/unaligned_splitter.sv
module unaligned_splitter #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_len,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  input  logic [AW-1:0] req_next_lw,
  output logic          frag_valid,
  input  logic          frag_ready,
  output logic [AW-1:0] frag_addr,
  output logic [2:0]    frag_len,
  output logic          frag_write,
  output logic [31:0]   frag_wdata,
  input  logic          frag_rvalid,
  input  logic [31:0]   frag_rdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);
  localparam logic [AW-1:0] LW_MASK = ~AW'(3);

  typedef enum logic [2:0] {S_IDLE, S_F0, S_W0, S_F1, S_W1, S_RSP} st_t;

  function automatic logic [31:0] lmask(input logic [2:0] n);
    lmask = n[2] ? 32'hFFFF_FFFF : ((32'd1 << {n[1:0], 3'b000}) - 32'd1);
  endfunction

  st_t           st_q;
  logic [AW-1:0] a_q, n_q;
  logic [2:0]    len_q;
  logic          wr_q;
  logic [31:0]   wd_q, acc_q;

  logic [1:0]  bo;
  logic        two;
  logic [2:0]  len0, len1;
  logic [5:0]  sh0;
  logic        hi;
  logic [31:0] fr_data;

  assign bo   = a_q[1:0];
  assign two  = (len_q == 3'd4 && bo != 2'd0) || (len_q == 3'd2 && bo == 2'd3);
  assign len0 = two ? (3'd4 - {1'b0, bo}) : len_q;
  assign len1 = len_q - len0;
  assign sh0  = {len0, 3'b000};
  assign hi   = (st_q == S_F1) || (st_q == S_W1);

  assign req_ready  = (st_q == S_IDLE);
  assign frag_valid = (st_q == S_F0) || (st_q == S_F1);
  assign frag_addr  = hi ? n_q : a_q;
  assign frag_len   = hi ? len1 : len0;
  assign frag_write = wr_q;
  assign frag_wdata = lmask(frag_len) & (hi ? (wd_q >> sh0) : wd_q);
  assign fr_data    = frag_rdata & lmask(frag_len);
  assign rsp_valid  = (st_q == S_RSP);
  assign rsp_rdata  = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      a_q   <= '0;
      n_q   <= '0;
      len_q <= 3'd0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
      acc_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          n_q   <= req_next_lw & LW_MASK;
          len_q <= req_len;
          wr_q  <= req_write;
          wd_q  <= req_wdata;
          acc_q <= '0;
          st_q  <= S_F0;
        end
        S_F0: if (frag_ready) st_q <= S_W0;
        S_W0: if (frag_rvalid) begin
          acc_q <= wr_q ? 32'd0 : fr_data;
          st_q  <= two ? S_F1 : S_RSP;
        end
        S_F1: if (frag_ready) st_q <= S_W1;
        S_W1: if (frag_rvalid) begin
          if (!wr_q) acc_q <= acc_q | (fr_data << sh0);
          st_q <= S_RSP;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unaligned_splitter_chk.sv
module unaligned_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          frag_valid,
  input logic          frag_ready,
  input logic [AW-1:0] frag_addr,
  input logic [2:0]    frag_len,
  input logic [31:0]   frag_wdata,
  input logic          rsp_valid
);
  logic second;

  always_ff @(posedge clk) begin
    if (!rst_n) second <= 1'b0;
    else if (req_valid && req_ready) second <= 1'b0;
    else if (frag_valid && frag_ready) second <= 1'b1;
  end

  // R10
  frag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && !frag_ready |=> frag_valid && $stable(frag_addr) && $stable(frag_len) && $stable(frag_wdata));

  // R2
  frag_in_lw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> (frag_len != 3'd0) && (({1'b0, frag_addr[1:0]} + frag_len) <= 3'd4));

  // R8
  second_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && second |-> frag_addr[1:0] == 2'b00 && frag_len <= 3'd3);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid |-> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !frag_valid && !req_ready);
endmodule

bind unaligned_splitter unaligned_splitter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
  .frag_len(frag_len), .frag_wdata(frag_wdata), .rsp_valid(rsp_valid)
);

// File: tb/test_unaligned_splitter.sv
module test_unaligned_splitter;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr, req_next_lw;
  logic [2:0]    req_len;
  logic [31:0]   req_wdata;
  logic          frag_valid, frag_ready, frag_write, frag_rvalid;
  logic [AW-1:0] frag_addr;
  logic [2:0]    frag_len;
  logic [31:0]   frag_wdata, frag_rdata;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;

  int checks = 0;
  int fails  = 0;

  unaligned_splitter #(.AW(AW)) i_unaligned_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .req_wdata(req_wdata), .req_next_lw(req_next_lw),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
    .frag_len(frag_len), .frag_write(frag_write), .frag_wdata(frag_wdata),
    .frag_rvalid(frag_rvalid), .frag_rdata(frag_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m(input int n);
    if (n >= 4) return 32'hFFFF_FFFF;
    return (32'd1 << (8 * n)) - 32'd1;
  endfunction

  task automatic access(input logic [31:0] addr, input int len, input logic wr,
                        input logic [31:0] wd, input logic [31:0] nxt, input int stall);
    int bo, nf;
    int fl[2];
    logic [31:0] fa[2], fw[2], rd[2], exp_r;
    string tag;
    bo = int'(addr[1:0]);
    if ((len == 4 && bo != 0) || (len == 2 && bo == 3)) begin
      nf = 2; fl[0] = 4 - bo; fl[1] = len - fl[0];
    end else begin
      nf = 1; fl[0] = len; fl[1] = 0;
    end
    tag = (nf == 1) ? "R2" : ((len == 2) ? "R4" : "R3");
    fa[0] = addr;
    fa[1] = {nxt[31:2], 2'b00};
    fw[0] = wd & m(fl[0]);
    fw[1] = (wd >> (8 * fl[0])) & m(fl[1]);
    rd[0] = $urandom;
    rd[1] = $urandom;
    exp_r = wr ? 32'd0 : (((rd[0] & m(fl[0])) | ((rd[1] & m(fl[1])) << (8 * fl[0]))) & m(len));

    chk("R11 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr = addr; req_len = 3'(len); req_write = wr;
    req_wdata = wd; req_next_lw = nxt;
    @(negedge clk);
    // garbage request held while busy (R11)
    req_addr = ~addr; req_len = 3'd1; req_write = ~wr; req_wdata = ~wd; req_next_lw = ~nxt;
    for (int i = 0; i < nf; i++) begin
      for (int s = 0; s < stall; s++) begin
        chk("R10 hold valid", {31'd0, frag_valid}, 32'd1);
        chk("R10 hold addr", frag_addr, fa[i]);
        chk("R10 hold len", {29'd0, frag_len}, 32'(fl[i]));
        chk("R11 busy ready", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
      end
      chk("R9 frag valid", {31'd0, frag_valid}, 32'd1);
      chk({tag, " frag addr"}, frag_addr, fa[i]);
      chk({tag, " frag len"}, {29'd0, frag_len}, 32'(fl[i]));
      chk("R7 frag dir", {31'd0, frag_write}, {31'd0, wr});
      if (i == 1) chk("R8 second base", {30'd0, frag_addr[1:0]}, 32'd0);
      if (wr) chk("R7 frag wdata", frag_wdata, fw[i]);
      frag_ready = 1'b1;
      @(negedge clk);
      frag_ready = 1'b0;
      chk("R9 one outstanding", {31'd0, frag_valid}, 32'd0);
      chk("R9 no early rsp", {31'd0, rsp_valid}, 32'd0);
      frag_rvalid = 1'b1; frag_rdata = rd[i];
      @(negedge clk);
      frag_rvalid = 1'b0; frag_rdata = $urandom;
    end
    chk("R9 rsp valid", {31'd0, rsp_valid}, 32'd1);
    chk(wr ? "R5 write rsp" : ((nf == 2 && len == 2) ? "R4 R6 result" : "R5 R6 result"), rsp_rdata, exp_r);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 rsp pulse", {31'd0, rsp_valid}, 32'd0);
    chk("R11 ready again", {31'd0, req_ready}, 32'd1);
    chk("R9 no extra frag", {31'd0, frag_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = 3'd4; req_write = 1'b0;
    req_wdata = '0; req_next_lw = '0; frag_ready = 1'b0; frag_rvalid = 1'b0; frag_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset frag", {31'd0, frag_valid}, 32'd0);
    chk("R1 reset rsp", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post reset frag", {31'd0, frag_valid}, 32'd0);
    chk("R1 post reset rsp", {31'd0, rsp_valid}, 32'd0);

    access(32'h0000_1000, 4, 1'b0, 32'h0, 32'h0000_1004, 0);
    access(32'h0000_2001, 4, 1'b0, 32'h0, 32'h0008_0003, 1);
    access(32'h0000_2FFE, 4, 1'b0, 32'h0, 32'h0009_1002, 2);
    access(32'h0000_3003, 4, 1'b0, 32'h0, 32'h000A_0001, 0);
    access(32'h0000_4000, 2, 1'b0, 32'h0, 32'h0000_4004, 0);
    access(32'h0000_4001, 2, 1'b0, 32'h0, 32'h0000_4004, 1);
    access(32'h0000_4002, 2, 1'b0, 32'h0, 32'h0000_4004, 0);
    access(32'h0000_4FFF, 2, 1'b0, 32'h0, 32'h0077_0002, 3);
    access(32'h0000_5003, 1, 1'b0, 32'h0, 32'h0000_5004, 0);
    access(32'h0000_6001, 4, 1'b1, 32'hA1B2_C3D4, 32'h0010_0003, 1);
    access(32'h0000_6002, 4, 1'b1, 32'h1122_3344, 32'h0010_0001, 0);
    access(32'h0000_6003, 4, 1'b1, 32'h5566_7788, 32'h0010_0002, 2);
    access(32'h0000_7003, 2, 1'b1, 32'hFFFF_9A5C, 32'h0011_0003, 0);
    access(32'h0000_7001, 2, 1'b1, 32'hDEAD_BEEF, 32'h0000_7004, 0);
    access(32'h0000_8000, 4, 1'b1, 32'hCAFE_F00D, 32'h0000_8004, 1);
    access(32'h0000_8002, 1, 1'b1, 32'h1234_56AB, 32'h0000_8004, 0);
    for (int k = 0; k < 24; k++)
      access($urandom, (k % 3 == 0) ? 1 : ((k % 3 == 1) ? 2 : 4), 1'(k % 2), $urandom, $urandom, k % 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule